// File: doc/BRIEF.md
# PHY Test-Port Command Sequencer

This block writes configuration bytes into a PHY through a slow, bit-banged test port. The port has three outputs: a test clock, a test enable and an 8-bit test data bus. A command is made of an 8-bit test code and a byte count. The block first runs a code-load phase that raises the enable around a falling test-clock edge. It then clocks each data byte in on a rising edge while the enable is low.

Data bytes are queued ahead of time in a small internal FIFO. Commands are taken on a valid/ready handshake. Every output state is held for a programmable number of system clocks, so that the PHY's setup and hold times are met at any system clock rate.

Only one of the three outputs changes at a time. The block changes nothing while it is idle.

Top module: `phy_test_seq`

## Requirements
- R1: After reset `testClk`=1, `testEn`=0, `testDin`=0x00, `cmdReady`=1, `done`=0 and `bufFull`=0.
- R2: A command is accepted on a rising `clk` edge with `cmdValid` and `cmdReady` both high. The code phase then runs five steps in order: `testClk` high, `testDin`=code, `testEn` high, `testClk` low, `testEn` low. The first step is visible right after the accepting edge, and at most one of the three outputs changes per cycle.
- R3: Each step holds its output state for exactly L system clocks, where L = `stepLen` sampled at acceptance. A `stepLen` of 0 is treated as 1.
- R4: Each data byte takes three steps in order: `testClk` low, `testDin`=byte, `testClk` high. Bytes leave the buffer in the order they were pushed.
- R5: A receiver that latches `testDin` on a falling `testClk` with `testEn` high sees the command code. A receiver that latches `testDin` on a rising `testClk` with `testEn` low sees exactly the `cmdCount` bytes, in order.
- R6: `done` is high for exactly one cycle, in the cycle right after the last step's hold ends. `cmdReady` is high in that same cycle. For a count of 1 or more, the command ends with `testClk`=1 and `testEn`=0.
- R7: A `cmdCount` of 0 runs only the code phase. `done` follows the `testEn`-low step, `testClk` is left at 0 and no byte is taken from the buffer.
- R8: If the buffer is empty when a byte is due, the sequencer holds `testClk` low and `testEn` low until a byte arrives, and then continues.
- R9: While a command runs, `cmdReady` is 0 and `cmdValid` is ignored. While idle, `testEn` stays 0 and `testDin` keeps its last value.
- R10: The buffer holds `BUF_DEPTH` bytes, and `bufFull` is 1 while it holds that many. A push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Sequencer idle, command can be taken |
| cmdCode | input | DATA_W | Test code of the command |
| cmdCount | input | CNT_W | Number of data bytes to send |
| stepLen | input | STEP_W | System clocks per output state (0 means 1) |
| bufPush | input | 1 | Write one byte into the data buffer |
| bufData | input | DATA_W | Byte to write into the buffer |
| bufFull | output | 1 | Buffer holds BUF_DEPTH bytes |
| testClk | output | 1 | PHY test clock |
| testEn | output | 1 | PHY test enable |
| testDin | output | DATA_W | PHY test data bus |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
A wrong step state or a wrong hold count shows at the output pins immediately, as an output pattern that departs from the computed waveform in some cycle. The bench compares every cycle of every command, so it sees the first such cycle. A bad byte counter or bad buffer pointers show up as a wrong number of bytes or wrong byte values at the receiver model, and as a `done` pulse that comes early or late. The bench finds these at the end of the command. A broken stall on an empty buffer shows as an enable or clock edge during a wait that should be quiet.

// File: rtl/phy_test_seq_pkg.sv
package phy_test_seq_pkg;

  // One state per held output step.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK_HI,
    ST_CODE,
    ST_EN_HI,
    ST_CLK_LO,
    ST_EN_LO,
    ST_BCLK_LO,
    ST_BYTE,
    ST_BCLK_HI
  } seq_state_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadCode;
    logic clkHigh;
    logic clkLow;
    logic enHigh;
    logic enLow;
    logic driveCode;
    logic driveByte;
  } seq_strobe_t;

endpackage

// File: rtl/phy_test_seq_ctrl.sv
module phy_test_seq_ctrl
  import phy_test_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [STEP_W-1:0] stepLen,
  input  logic              bufEmpty,
  output logic              cmdReady,
  output logic              done,
  output seq_strobe_t       strobe
);

  localparam logic [STEP_W-1:0] ONE_STEP = STEP_W'(1);

  seq_state_t        curState, nextState;
  logic [STEP_W-1:0] holdCnt;
  logic [STEP_W-1:0] holdReload;
  logic [CNT_W-1:0]  remain;
  logic              stepDone;
  logic              loadHold;
  logic              finish;
  logic              acceptCmd;
  logic              byteSent;
  logic [STEP_W-1:0] acceptLen;

  assign stepDone  = (holdCnt == '0);
  assign cmdReady  = (curState == ST_IDLE);
  assign acceptCmd = cmdReady && cmdValid;
  assign acceptLen = ((stepLen == '0) ? ONE_STEP : stepLen) - ONE_STEP;

  always_comb begin
    strobe    = '0;
    nextState = curState;
    loadHold  = 1'b0;
    finish    = 1'b0;
    byteSent  = 1'b0;
    unique case (curState)
      ST_IDLE: if (cmdValid) begin
        strobe.loadCode = 1'b1;
        strobe.clkHigh  = 1'b1;
        nextState       = ST_CLK_HI;
        loadHold        = 1'b1;
      end
      ST_CLK_HI: if (stepDone) begin
        strobe.driveCode = 1'b1;
        nextState        = ST_CODE;
        loadHold         = 1'b1;
      end
      ST_CODE: if (stepDone) begin
        strobe.enHigh = 1'b1;
        nextState     = ST_EN_HI;
        loadHold      = 1'b1;
      end
      ST_EN_HI: if (stepDone) begin
        strobe.clkLow = 1'b1;
        nextState     = ST_CLK_LO;
        loadHold      = 1'b1;
      end
      ST_CLK_LO: if (stepDone) begin
        strobe.enLow = 1'b1;
        nextState    = ST_EN_LO;
        loadHold     = 1'b1;
      end
      ST_EN_LO: if (stepDone) begin
        if (remain == '0) begin
          finish    = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strobe.clkLow = 1'b1;
          nextState     = ST_BCLK_LO;
          loadHold      = 1'b1;
        end
      end
      ST_BCLK_LO: if (stepDone && !bufEmpty) begin
        strobe.driveByte = 1'b1;
        nextState        = ST_BYTE;
        loadHold         = 1'b1;
      end
      ST_BYTE: if (stepDone) begin
        strobe.clkHigh = 1'b1;
        nextState      = ST_BCLK_HI;
        loadHold       = 1'b1;
      end
      ST_BCLK_HI: if (stepDone) begin
        byteSent = 1'b1;
        if (remain == CNT_W'(1)) begin
          finish    = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strobe.clkLow = 1'b1;
          nextState     = ST_BCLK_LO;
          loadHold      = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState   <= ST_IDLE;
      holdCnt    <= '0;
      holdReload <= '0;
      remain     <= '0;
      done       <= 1'b0;
    end else begin
      curState <= nextState;
      done     <= finish;
      if (acceptCmd) begin
        holdReload <= acceptLen;
        holdCnt    <= acceptLen;
        remain     <= cmdCount;
      end else begin
        if (loadHold)
          holdCnt <= holdReload;
        else if (!stepDone)
          holdCnt <= holdCnt - ONE_STEP;
        if (byteSent)
          remain <= remain - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/phy_test_seq_dp.sv
module phy_test_seq_dp
  import phy_test_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [DATA_W-1:0] cmdCode,
  input  logic              bufPush,
  input  logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              bufEmpty,
  output logic              testClk,
  output logic              testEn,
  output logic [DATA_W-1:0] testDin
);

  localparam int PTR_W = $clog2(BUF_DEPTH);

  logic [DATA_W-1:0] bufMem [BUF_DEPTH];
  logic [PTR_W:0]    wrPtr, rdPtr;
  logic [DATA_W-1:0] codeReg;
  logic              pushOk;

  assign bufEmpty = (wrPtr == rdPtr);
  assign bufFull  = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                    (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign pushOk   = bufPush && !bufFull;

  always_ff @(posedge clk) begin
    if (pushOk)
      bufMem[wrPtr[PTR_W-1:0]] <= bufData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      codeReg <= '0;
      testClk <= 1'b1;
      testEn  <= 1'b0;
      testDin <= '0;
    end else begin
      if (pushOk)
        wrPtr <= wrPtr + 1'b1;
      if (strobe.driveByte)
        rdPtr <= rdPtr + 1'b1;
      if (strobe.loadCode)
        codeReg <= cmdCode;
      if (strobe.clkHigh)
        testClk <= 1'b1;
      else if (strobe.clkLow)
        testClk <= 1'b0;
      if (strobe.enHigh)
        testEn <= 1'b1;
      else if (strobe.enLow)
        testEn <= 1'b0;
      if (strobe.driveCode)
        testDin <= codeReg;
      else if (strobe.driveByte)
        testDin <= bufMem[rdPtr[PTR_W-1:0]];
    end
  end

endmodule

// File: rtl/phy_test_seq.sv
module phy_test_seq
  import phy_test_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int STEP_W    = 4,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [DATA_W-1:0] cmdCode,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [STEP_W-1:0] stepLen,
  input  logic              bufPush,
  input  logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              testClk,
  output logic              testEn,
  output logic [DATA_W-1:0] testDin,
  output logic              done
);

  seq_strobe_t strobe;
  logic        bufEmpty;

  phy_test_seq_ctrl #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCount (cmdCount),
    .stepLen  (stepLen),
    .bufEmpty (bufEmpty),
    .cmdReady (cmdReady),
    .done     (done),
    .strobe   (strobe)
  );

  phy_test_seq_dp #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdCode  (cmdCode),
    .bufPush  (bufPush),
    .bufData  (bufData),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .testClk  (testClk),
    .testEn   (testEn),
    .testDin  (testDin)
  );

endmodule

// File: rtl/phy_test_seq_chk.sv
module phy_test_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              testClk,
  input logic              testEn,
  input logic [DATA_W-1:0] testDin,
  input logic              done
);

  // R2: only one test-port output moves per cycle
  assert_one_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({testClk != $past(testClk), testEn != $past(testEn),
                testDin != $past(testDin)}) <= 1);

  // R2: enable rises while the test clock is high
  assert_en_rise_clk_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testEn) |-> testClk);

  // R2: enable falls only after the test clock has dropped
  assert_en_fall_clk_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(testEn) |-> !testClk);

  // R6: done lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done comes with the sequencer back in idle and enable low
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cmdReady && !testEn));

  // R9: enable is never high while idle
  assert_idle_en_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !testEn);

endmodule

bind phy_test_seq phy_test_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdReady (cmdReady),
  .testClk  (testClk),
  .testEn   (testEn),
  .testDin  (testDin),
  .done     (done)
);

// File: tb/phy_test_seq_test.sv
`timescale 1ns/1ps
module phy_test_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdReady;
  logic [7:0] cmdCode = '0;
  logic [3:0] cmdCount = '0;
  logic [3:0] stepLen = '0;
  logic       bufPush = 1'b0;
  logic [7:0] bufData = '0;
  logic       bufFull;
  logic       testClk, testEn;
  logic [7:0] testDin;
  logic       done;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] expB [16];
  logic [7:0] rxBytes [16];
  int         rxN = 0;
  logic [7:0] rxCode = '0;

  always #5 clk = ~clk;

  phy_test_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdCode(cmdCode), .cmdCount(cmdCount), .stepLen(stepLen),
    .bufPush(bufPush), .bufData(bufData), .bufFull(bufFull),
    .testClk(testClk), .testEn(testEn), .testDin(testDin), .done(done)
  );

  // Receiver model of the PHY test port.
  always @(testClk) begin
    if (rstN) begin
      if (!testClk && testEn) begin
        rxCode = testDin;
        rxN = 0;
      end else if (testClk && !testEn) begin
        if (rxN < 16) rxBytes[rxN] = testDin;
        rxN = rxN + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    bufData = b;
    bufPush = 1'b1;
    @(negedge clk);
    bufPush = 1'b0;
  endtask

  // Runs one command and checks it cycle by cycle; expects expB[0..cnt-1] queued.
  task automatic runCmd(input logic [7:0] code, input int cnt, input int len);
    logic [7:0] prev;
    int L, tot, mism, firstT, actV, expV;
    prev = testDin;
    L = (len == 0) ? 1 : len;
    tot = L * (5 + 3 * cnt);
    mism = 0; firstT = -1; actV = 0; expV = 0;
    cmdCode = code; cmdCount = 4'(cnt); stepLen = 4'(len);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int t = 0; t < tot; t++) begin
      int s, j, k;
      logic eClk, eEn;
      logic [7:0] eDin;
      s = t / L;
      if (s < 5) begin
        eClk = (s < 3);
        eEn  = (s == 2) || (s == 3);
        eDin = (s == 0) ? prev : code;
      end else begin
        j = (s - 5) / 3;
        k = (s - 5) % 3;
        eClk = (k == 2);
        eEn  = 1'b0;
        eDin = (k != 0) ? expB[j] : ((j == 0) ? code : expB[j-1]);
      end
      if ({testClk, testEn, testDin, done, cmdReady} != {eClk, eEn, eDin, 2'b00}) begin
        if (firstT < 0) begin
          firstT = t;
          actV = {testClk, testEn, testDin, done, cmdReady};
          expV = {eClk, eEn, eDin, 2'b00};
        end
        mism = mism + 1;
      end
      @(negedge clk);
    end
    check(mism == 0, "R2/R3/R4", $sformatf("waveform len=%0d cnt=%0d t=%0d", len, cnt, firstT), actV, expV);
    check(done && cmdReady, "R6", "done and ready after last step", {done, cmdReady}, 2'b11);
    check(testClk == (cnt > 0) && !testEn, (cnt > 0) ? "R6" : "R7", "end state clk/en",
          {testClk, testEn}, {(cnt > 0), 1'b0});
    @(negedge clk);
    check(!done, "R6", "done falls after one cycle", done, 0);
    check(rxCode == code, "R5", "received code", rxCode, code);
    check(rxN == cnt, "R5", "received byte count", rxN, cnt);
    for (int i = 0; i < cnt; i++)
      check(rxBytes[i] == expB[i], "R5", $sformatf("received byte %0d", i), rxBytes[i], expB[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(testClk && !testEn && testDin == 8'h00 && cmdReady && !done && !bufFull, "R1",
          "reset outputs", {testClk, testEn, testDin, cmdReady, done, bufFull}, 12'b1000_0000_0100);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep of step length and byte count (R2, R3, R4, R5, R6, R7).
    for (int len = 0; len < 4; len++) begin
      for (int cnt = 0; cnt < 5; cnt++) begin
        logic [7:0] code;
        code = 8'((cnt * 16 + len) * 7 + 3);
        for (int i = 0; i < cnt; i++) begin
          expB[i] = code ^ 8'(8'h3C + i * 29);
          pushByte(expB[i]);
        end
        runCmd(code, cnt, len);
      end
    end

    // R7: zero-count command leaves a queued byte for the next command.
    expB[0] = 8'hC3;
    pushByte(8'hC3);
    runCmd(8'h42, 0, 2);
    runCmd(8'h43, 1, 1);

    // R9: idle holds the data bus and keeps enable low.
    repeat (10) @(negedge clk);
    check(testDin == 8'hC3 && !testEn && testClk, "R9", "idle hold",
          {testClk, testEn, testDin}, {2'b10, 8'hC3});

    // R8 and R9: stall on an empty buffer; a second command is ignored.
    pushByte(8'h81);
    cmdCode = 8'h6E; cmdCount = 4'd2; stepLen = 4'd1;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (20) @(negedge clk);
    check(!testClk && !testEn && !done && !cmdReady, "R8", "stalled with clk and en low",
          {testClk, testEn, done, cmdReady}, 0);
    cmdCode = 8'h5A; cmdCount = 4'd1; cmdValid = 1'b1;
    repeat (4) @(negedge clk);
    cmdValid = 1'b0;
    check(!cmdReady && !testEn, "R9", "busy ignores command", {cmdReady, testEn}, 0);
    pushByte(8'h92);
    for (int i = 0; i < 50 && !done; i++) @(negedge clk);
    check(done, "R8", "completes after late byte", done, 1);
    check(rxCode == 8'h6E, "R9", "code of ignored command absent", rxCode, 8'h6E);
    check(rxN == 2 && rxBytes[0] == 8'h81 && rxBytes[1] == 8'h92, "R8", "bytes after stall",
          {rxBytes[0], rxBytes[1]}, 16'h8192);
    repeat (3) @(negedge clk);
    check(cmdReady && !testEn, "R9", "idle after stalled command", {cmdReady, testEn}, 2'b10);

    // R10: buffer fills at BUF_DEPTH, extra push dropped.
    for (int i = 0; i < 4; i++) begin
      expB[i] = 8'hA0 + 8'(i);
      pushByte(expB[i]);
    end
    check(bufFull, "R10", "full after depth pushes", bufFull, 1);
    pushByte(8'hA4);
    runCmd(8'h17, 4, 1);
    check(!bufFull, "R10", "not full after drain", bufFull, 0);
    expB[0] = 8'hB0;
    pushByte(8'hB0);
    runCmd(8'h18, 1, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule